// File: doc/BRIEF.md
# Sine Tone Generator with Fractional Phase Stepping

This block produces a periodic tone from a single stored sine cycle. A programmable divider on the master clock produces a sample tick. On every tick a 16-bit phase register advances by a programmed step. The step is an unsigned fixed-point number with eight integer bits and eight fraction bits. The integer byte of the phase, masked to a power-of-two table length, picks an entry from a 16-entry, 4-bit sine table. The tone frequency is therefore the sample rate times the step, divided by the active table length.

The chosen entry is latched as an unsigned code and held for one full sample period. A pulse-width stage whose frame equals that period drives a one-bit output, with a duty cycle in proportion to the code. A narrow write port loads three values: the phase step, the table mask and the divide value. Any power-of-two table length up to 16 can be chosen at run time. A shorter table walks the stored cycle with a coarser stride, so every length still spans one full cycle.

Top module: `tone_synth`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `sample_code` is mid-scale 8 and `sample_tick` is low. Reset returns the phase to zero, the step to 0, the mask to 0xF and the divide value to 16.
- R2: With a divide value D of 2 or more, `sample_tick` is high for one clock in every D clocks.
- R3: A divide value of 0 or 1 acts as 2, so ticks are never closer than two clocks apart.
- R4: The stored table, indexed 0 to 15, holds 8, 11, 13, 14, 15, 14, 13, 11, 8, 5, 3, 2, 1, 2, 3, 5. On each tick, `sample_code` takes the entry chosen by the phase held before that tick, and the phase then grows by the step.
- R5: The step's low byte is a fraction of 1/256. Step 0x0080 repeats each table entry for two ticks.
- R6: The table address is (integer byte AND mask) shifted left by 4 minus the number of ones in the mask. Mask 0x7 gives an 8-entry cycle of every second entry. Indices past the last entry return to entry 0.
- R7: A new step, written while the tone runs, is first used at the next tick. The phase carries on from its current value.
- R8: The phase wraps at 16 bits. A step of 0x0F00 walks the table downwards, one entry per tick.
- R9: In each sample period of D clocks that follows a tick, `pwm_out` is high for the first ceil(code*D/16) clocks and low for the rest. Here code is the `sample_code` held in that period.
- R10: Writes use `cfg_sel` 0 for the step (16 bits), 1 for the mask (low 4 bits) and 2 for the divide value (16 bits). A write lands on the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the settings |
| cfg_sel | input | 2 | Setting select: 0 step, 1 mask, 2 divide |
| cfg_wdata | input | 16 | Write data |
| sample_tick | output | 1 | One-clock pulse; the next edge advances phase and code |
| sample_code | output | 4 | Latched unsigned table sample |
| pwm_out | output | 1 | Pulse-width output, one frame per sample period |

## Verification
A new `sample_code` appears on the clock edge where `sample_tick` is high. The bench therefore waits for a falling edge that shows the tick, and reads the code on the following falling edge. It times the period by counting falling edges between two that show a tick. It counts `pwm_out` highs over exactly the D falling edges after a tick, and those fall inside the new frame. A written value lands on the edge between the two falling edges of the write task. A new step is expected to affect only the sample after the next tick, and the reference phase model applies the old step once more to match.

// File: rtl/tone_pkg.sv
package tone_pkg;

   localparam int unsigned SINE_AW  = 4;
   localparam int unsigned SINE_W   = 4;
   localparam int unsigned SINE_MID = 8;

   typedef enum logic [1:0] {
      CFG_STEP = 2'd0,
      CFG_MASK = 2'd1,
      CFG_DIV  = 2'd2,
      CFG_NONE = 2'd3
   } cfg_sel_e;

   // one sine cycle, 16 points, 8 + round(7*sin(2*pi*k/16))
   function automatic logic [SINE_W-1:0] sine16(input int unsigned k);
      logic [SINE_W-1:0] v;
      case (k % 16)
         0:       v = 4'd8;
         1:       v = 4'd11;
         2:       v = 4'd13;
         3:       v = 4'd14;
         4:       v = 4'd15;
         5:       v = 4'd14;
         6:       v = 4'd13;
         7:       v = 4'd11;
         8:       v = 4'd8;
         9:       v = 4'd5;
         10:      v = 4'd3;
         11:      v = 4'd2;
         12:      v = 4'd1;
         13:      v = 4'd2;
         14:      v = 4'd3;
         default: v = 4'd5;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/tone_tick_div.sv
module tone_tick_div #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick,
   output logic [DIV_W-1:0] frame_pos,
   output logic [DIV_W-1:0] span
);

   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

   logic [DIV_W-1:0] cnt_q;

   // divide values below the minimum are raised to it
   always_comb span = (div_val < MIN_DIV) ? MIN_DIV : div_val;

   // >= keeps the counter from running away after span shrinks
   assign tick      = (cnt_q >= (span - DIV_W'(1)));
   assign frame_pos = cnt_q;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + DIV_W'(1);
   end

endmodule

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
   parameter int unsigned PH_W   = 16,
   parameter int unsigned FRAC_W = 8,
   parameter int unsigned TBL_AW = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic [PH_W-1:0]   step,
   input  logic [TBL_AW-1:0] mask,
   output logic [TBL_AW-1:0] addr
);

   localparam int unsigned INT_W = PH_W - FRAC_W;

   logic [PH_W-1:0]   phase_q;
   logic [TBL_AW-1:0] idx;
   int unsigned       ones;

   initial begin
      assert (INT_W >= TBL_AW) else $error("integer part narrower than table address");
   end

   always_ff @(posedge clk) begin
      if (rst)       phase_q <= '0;
      else if (tick) phase_q <= phase_q + step;
   end

   // masked integer index, stretched so a short table still spans one cycle
   always_comb begin
      idx  = phase_q[FRAC_W +: TBL_AW] & mask;
      ones = $countones(mask);
      addr = idx << (TBL_AW - ones);
   end

endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
   parameter int unsigned TBL_AW = 4,
   parameter int unsigned SMP_W  = 4
) (
   input  logic [TBL_AW-1:0] addr,
   output logic [SMP_W-1:0]  data
);

   localparam int unsigned DEPTH = 1 << TBL_AW;

   logic [SMP_W-1:0] tbl [DEPTH];

   initial begin
      assert (TBL_AW == tone_pkg::SINE_AW && SMP_W == tone_pkg::SINE_W)
         else $error("table shape must be 16 x 4");
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      assign tbl[k] = SMP_W'(tone_pkg::sine16(k));
   end

   assign data = tbl[addr];

endmodule

// File: rtl/tone_pwm.sv
module tone_pwm #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned SMP_W = 4,
   parameter int unsigned MID   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [SMP_W-1:0] next_code,
   input  logic [DIV_W-1:0] frame_pos,
   input  logic [DIV_W-1:0] span,
   output logic [SMP_W-1:0] code,
   output logic             pwm
);

   localparam int unsigned PROD_W = DIV_W + SMP_W;

   logic [SMP_W-1:0]  code_q;
   logic [PROD_W-1:0] pos_scaled;
   logic [PROD_W-1:0] level;

   always_ff @(posedge clk) begin
      if (rst)       code_q <= SMP_W'(MID);
      else if (tick) code_q <= next_code;
   end

   // high while pos * 2^SMP_W < code * span
   always_comb begin
      pos_scaled = {frame_pos, {SMP_W{1'b0}}};
      level      = PROD_W'(code_q) * PROD_W'(span);
   end

   assign pwm  = (pos_scaled < level);
   assign code = code_q;

endmodule

// File: rtl/tone_synth.sv
module tone_synth #(
   parameter int unsigned PH_W    = 16,
   parameter int unsigned FRAC_W  = 8,
   parameter int unsigned TBL_AW  = 4,
   parameter int unsigned SMP_W   = 4,
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned CFG_W   = 16,
   parameter int unsigned DIV_RST = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             sample_tick,
   output logic [SMP_W-1:0] sample_code,
   output logic             pwm_out
);
   import tone_pkg::*;

   logic [PH_W-1:0]   step_q;
   logic [TBL_AW-1:0] mask_q;
   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  frame_pos;
   logic [DIV_W-1:0]  span;
   logic [TBL_AW-1:0] tbl_addr;
   logic [SMP_W-1:0]  tbl_data;

   initial begin
      assert (CFG_W >= PH_W && CFG_W >= DIV_W) else $error("write port too narrow");
      assert (FRAC_W < PH_W) else $error("no integer phase bits");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= '0;
         mask_q <= '1;
         div_q  <= DIV_W'(DIV_RST);
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_sel))
            CFG_STEP: step_q <= cfg_wdata[PH_W-1:0];
            CFG_MASK: mask_q <= cfg_wdata[TBL_AW-1:0];
            CFG_DIV:  div_q  <= cfg_wdata[DIV_W-1:0];
            default:  ;
         endcase
      end
   end

   tone_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .div_val(div_q),
      .tick(sample_tick), .frame_pos(frame_pos), .span(span)
   );

   tone_phase_acc #(.PH_W(PH_W), .FRAC_W(FRAC_W), .TBL_AW(TBL_AW)) u_acc (
      .clk(clk), .rst(rst), .tick(sample_tick),
      .step(step_q), .mask(mask_q), .addr(tbl_addr)
   );

   tone_sine_rom #(.TBL_AW(TBL_AW), .SMP_W(SMP_W)) u_rom (
      .addr(tbl_addr), .data(tbl_data)
   );

   tone_pwm #(.DIV_W(DIV_W), .SMP_W(SMP_W), .MID(SINE_MID)) u_pwm (
      .clk(clk), .rst(rst), .tick(sample_tick), .next_code(tbl_data),
      .frame_pos(frame_pos), .span(span), .code(sample_code), .pwm(pwm_out)
   );

endmodule

// File: rtl/tone_synth_chk.sv
module tone_synth_chk #(
   parameter int unsigned SMP_W = 4,
   parameter int unsigned MID   = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             sample_tick,
   input logic [SMP_W-1:0] sample_code,
   input logic             pwm_out
);

   // R1
   reset_mid_chk: assert property (@(posedge clk)
      rst |=> (sample_code == SMP_W'(MID) && !sample_tick));

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
      sample_tick |=> !sample_tick);

   // R4
   code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(sample_tick) && !$past(rst)) |-> $stable(sample_code));

   // R9
   pwm_start_chk: assert property (@(posedge clk) disable iff (rst)
      sample_tick |=> (pwm_out == (sample_code != '0)));

endmodule

bind tone_synth tone_synth_chk #(.SMP_W(SMP_W), .MID(tone_pkg::SINE_MID)) u_chk (
   .clk(clk), .rst(rst), .sample_tick(sample_tick),
   .sample_code(sample_code), .pwm_out(pwm_out)
);

// File: tb/tb_tone_synth.sv
`timescale 1ns/1ps
module tb_tone_synth;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_wdata = '0;
   logic        sample_tick;
   logic [3:0]  sample_code;
   logic        pwm_out;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tone_synth dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .sample_tick(sample_tick),
      .sample_code(sample_code), .pwm_out(pwm_out)
   );

   function automatic int ref_sine(input int k);
      int t [16] = '{8, 11, 13, 14, 15, 14, 13, 11, 8, 5, 3, 2, 1, 2, 3, 5};
      return t[k & 15];
   endfunction

   function automatic int ref_addr(input int phase, input int mask);
      int m, i, ones;
      m = mask & 15;
      i = (phase >> 8) & m;
      ones = 0;
      for (int b = 0; b < 4; b++) ones += (m >> b) & 1;
      return (i << (4 - ones)) & 15;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(input int sel, input int data);
      cfg_we    = 1'b1;
      cfg_sel   = 2'(sel);
      cfg_wdata = 16'(data);
      @(negedge clk);
      cfg_we    = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic next_sample(output int v);
      while (!sample_tick) @(negedge clk);
      @(negedge clk);
      v = sample_code;
   endtask

   task automatic measure_period(output int p);
      while (!sample_tick) @(negedge clk);
      p = 0;
      do begin
         @(negedge clk);
         p++;
      end while (!sample_tick && p < 100);
   endtask

   // R1
   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 code in reset", sample_code, 8);
      chk("R1 tick in reset", sample_tick, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 code after reset", sample_code, 8);
      chk("R1 tick after reset", sample_tick, 0);
   endtask

   // R2 R3 R10
   task automatic t_period();
      int p;
      do_reset();
      measure_period(p);
      chk("R2 default divide 16", p, 16);
      cfg(2, 5);
      measure_period(p);
      measure_period(p);
      chk("R2 R10 divide 5", p, 5);
      cfg(2, 0);
      measure_period(p);
      measure_period(p);
      chk("R3 divide 0", p, 2);
      cfg(2, 1);
      measure_period(p);
      measure_period(p);
      chk("R3 divide 1", p, 2);
   endtask

   // R4 R5 R6 R8: sequence against the phase model
   task automatic t_seq(input string req, input int mask, input int div,
                        input int step, input int count);
      int phase, v;
      do_reset();
      cfg(2, div);
      cfg(1, mask);
      cfg(0, step);
      phase = 0;
      for (int k = 0; k < count; k++) begin
         next_sample(v);
         chk(req, v, ref_sine(ref_addr(phase, mask)));
         phase = (phase + step) & 16'hFFFF;
      end
   endtask

   // R7
   task automatic t_step_change();
      int phase, v, step;
      do_reset();
      cfg(2, 8);
      step = 16'h0100;
      cfg(0, step);
      phase = 0;
      for (int k = 0; k < 3; k++) begin
         next_sample(v);
         chk("R7 before change", v, ref_sine(ref_addr(phase, 15)));
         phase = (phase + step) & 16'hFFFF;
      end
      step = 16'h0300;
      cfg(0, step);
      for (int k = 0; k < 5; k++) begin
         next_sample(v);
         chk("R7 after change", v, ref_sine(ref_addr(phase, 15)));
         phase = (phase + step) & 16'hFFFF;
      end
   endtask

   // R9
   task automatic t_pwm(input int div, input int frames);
      int highs, code;
      do_reset();
      cfg(2, div);
      cfg(0, 16'h0100);
      for (int f = 0; f < frames; f++) begin
         while (!sample_tick) @(negedge clk);
         highs = 0;
         code  = 0;
         for (int j = 0; j < div; j++) begin
            @(negedge clk);
            if (j == 0) code = sample_code;
            highs += int'(pwm_out);
         end
         chk("R9 pwm high clocks", highs, (code * div + 15) / 16);
      end
   endtask

   initial begin
      t_reset();
      t_period();
      t_seq("R4 integer step", 15, 4, 16'h0100, 18);
      t_seq("R5 half step", 15, 3, 16'h0080, 10);
      t_seq("R6 eight-entry cycle", 7, 3, 16'h0100, 10);
      t_seq("R6 eight-entry fractional step", 7, 3, 16'h00CD, 12);
      t_seq("R8 16-bit wrap", 15, 3, 16'h0F00, 20);
      t_step_change();
      t_pwm(16, 7);
      t_pwm(10, 6);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule